// File: doc/BRIEF.md
# SD host interrupt status controller

This block gathers the single-cycle event pulses produced by the command and data engines of an SD/SDIO host. It keeps them in two sticky status registers: a normal group and an error group. Each event passes two masks. The status-enable mask decides whether the event is recorded. The interrupt-enable mask decides whether a recorded bit drives the CPU interrupt line.

Software reaches all six registers through a 32-bit register port. It clears recorded events by writing ones. The usual habit is to read a status register and write the same value back. Because the interrupt-enable mask is kept apart from the recorded state, a driver can pick which completion event wakes it for each command while every other enabled event stays visible in status. Bit 15 of the normal group is not stored. It is derived from the error group and acts as one summary flag for all recorded errors.

Top module: `sd_irq_status`

## Requirements
- R1: After reset all six registers read 0 and irq_o is 0.
- R2: An event pulse on nrm_evt_i or err_evt_i sets the status bit at the same index on the next clock edge, and only when that index's status-enable bit is 1. Normal events sit at bits 0-5 and 8-14, for example command done at bit 0, transfer done at bit 1 and auto stop done at bit 13. Error events sit at bits 0-6 and 8-14, for example data timeout at bit 4.
- R3: A recorded status bit stays set without new events, and it also stays set after its status-enable bit is cleared.
- R4: Writing to a status register clears each bit where the write data is 1 and leaves the bits where it is 0. Writing back a value that was just read clears exactly the bits that were read.
- R5: Normal status bit 15 reads 1 exactly when the error status register is non-zero. Writes to bit 15 have no effect on it, and it returns to 0 once the error register has been cleared.
- R6: irq_o is a register output. It is 1 in the cycle after some status bit (normal bit 15 included) and its interrupt-enable bit are both 1, and it is 0 in the cycle after no such pair exists.
- R7: The interrupt-enable masks do not affect recording. A bit recorded while its interrupt-enable is 0 raises irq_o once that enable is later set.
- R8: If an event and a clearing write hit the same status bit in one cycle, the bit ends set.
- R9: Reserved positions read 0 and ignore writes and events: bits 6 and 7 of the normal registers (and normal status-enable bit 15), bits 7 and 15 of the error registers, and bits 31:16 of every register.
- R10: Register offsets are 0x60 for normal status, 0x64 for error status, 0x68 and 0x6C for the normal and error status-enable masks, and 0x70 and 0x74 for the normal and error interrupt-enable masks. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nrm_evt_i | input | 16 | Normal event pulses, one bit per event index |
| err_evt_i | input | 16 | Error event pulses, one bit per event index |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
A corrupted status bit shows up on reg_rdata_o at the matching offset right after the edge that stored it. If its interrupt-enable bit is set, it also shows on irq_o one edge later. A wrong summary bit only shows in the normal status word, so the bench reads that word after every change to the error group. A wrong mask either lets a disabled event reach the readable status or keeps an enabled one out of it. The bench catches either case in the cycle after the pulse and then checks irq_o in the cycle that follows.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned GW = 16;

  localparam logic [7:0] OFF_NSTAT = 8'h60;
  localparam logic [7:0] OFF_ESTAT = 8'h64;
  localparam logic [7:0] OFF_NSTEN = 8'h68;
  localparam logic [7:0] OFF_ESTEN = 8'h6C;
  localparam logic [7:0] OFF_NIE   = 8'h70;
  localparam logic [7:0] OFF_EIE   = 8'h74;

  // storable positions per group
  localparam logic [GW-1:0] NRM_STAT_MASK = 16'h7F3F;
  localparam logic [GW-1:0] NRM_STEN_MASK = 16'h7F3F;
  localparam logic [GW-1:0] NRM_IE_MASK   = 16'hFF3F;
  localparam logic [GW-1:0] ERR_MASK      = 16'h7F7F;

  localparam int unsigned SUM_BIT = 15;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_NSTAT, SEL_ESTAT, SEL_NSTEN, SEL_ESTEN, SEL_NIE, SEL_EIE
  } reg_sel_e;
endpackage

// File: rtl/sd_irq_dec.sv
module sd_irq_dec
  import sd_irq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  always_comb begin
    unique case (addr_i)
      AW'(OFF_NSTAT): sel_o = SEL_NSTAT;
      AW'(OFF_ESTAT): sel_o = SEL_ESTAT;
      AW'(OFF_NSTEN): sel_o = SEL_NSTEN;
      AW'(OFF_ESTEN): sel_o = SEL_ESTEN;
      AW'(OFF_NIE):   sel_o = SEL_NIE;
      AW'(OFF_EIE):   sel_o = SEL_EIE;
      default:        sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sd_irq_group.sv
module sd_irq_group #(
  parameter int unsigned    W         = 16,
  parameter logic [W-1:0]   STAT_MASK = '1,
  parameter logic [W-1:0]   STEN_MASK = '1,
  parameter logic [W-1:0]   IE_MASK   = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stat_we_i,
  input  logic         sten_we_i,
  input  logic         ie_we_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] sten_o,
  output logic [W-1:0] ie_o
);
  logic [W-1:0] stat_q, sten_q, ie_q;
  logic [W-1:0] clr, set, stat_d;

  assign clr    = stat_we_i ? wdata_i : '0;
  assign set    = evt_i & sten_q;
  // set after clear: a coincident event survives
  assign stat_d = ((stat_q & ~clr) | set) & STAT_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      sten_q <= '0;
      ie_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (sten_we_i) sten_q <= wdata_i & STEN_MASK;
      if (ie_we_i)   ie_q   <= wdata_i & IE_MASK;
    end
  end

  assign stat_o = stat_q;
  assign sten_o = sten_q;
  assign ie_o   = ie_q;
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sd_irq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] nrm_evt_i,
  input  logic [GW-1:0] err_evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic [GW-1:0] wdata;
  logic [GW-1:0] nrm_stat, nrm_sten, nrm_ie;
  logic [GW-1:0] err_stat, err_sten, err_ie;
  logic [GW-1:0] nrm_view;
  logic          pending, irq_q;

  assign wdata = reg_wdata_i[GW-1:0];

  sd_irq_dec #(.AW(AW)) u_dec (.addr_i(reg_addr_i), .sel_o(sel));

  sd_irq_group #(
    .W(GW), .STAT_MASK(NRM_STAT_MASK), .STEN_MASK(NRM_STEN_MASK), .IE_MASK(NRM_IE_MASK)
  ) u_nrm (
    .clk_i, .rst_ni,
    .evt_i(nrm_evt_i), .wdata_i(wdata),
    .stat_we_i(reg_we_i && sel == SEL_NSTAT),
    .sten_we_i(reg_we_i && sel == SEL_NSTEN),
    .ie_we_i  (reg_we_i && sel == SEL_NIE),
    .stat_o(nrm_stat), .sten_o(nrm_sten), .ie_o(nrm_ie)
  );

  sd_irq_group #(
    .W(GW), .STAT_MASK(ERR_MASK), .STEN_MASK(ERR_MASK), .IE_MASK(ERR_MASK)
  ) u_err (
    .clk_i, .rst_ni,
    .evt_i(err_evt_i), .wdata_i(wdata),
    .stat_we_i(reg_we_i && sel == SEL_ESTAT),
    .sten_we_i(reg_we_i && sel == SEL_ESTEN),
    .ie_we_i  (reg_we_i && sel == SEL_EIE),
    .stat_o(err_stat), .sten_o(err_sten), .ie_o(err_ie)
  );

  // summary bit is derived, never stored
  always_comb begin
    nrm_view          = nrm_stat;
    nrm_view[SUM_BIT] = |err_stat;
  end

  assign pending = (|(nrm_view & nrm_ie)) | (|(err_stat & err_ie));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pending;
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_NSTAT: reg_rdata_o[GW-1:0] = nrm_view;
      SEL_ESTAT: reg_rdata_o[GW-1:0] = err_stat;
      SEL_NSTEN: reg_rdata_o[GW-1:0] = nrm_sten;
      SEL_ESTEN: reg_rdata_o[GW-1:0] = err_sten;
      SEL_NIE:   reg_rdata_o[GW-1:0] = nrm_ie;
      SEL_EIE:   reg_rdata_o[GW-1:0] = err_ie;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sd_irq_status_chk.sv
module sd_irq_status_chk
  import sd_irq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [GW-1:0] nrm_evt_i,
  input logic [GW-1:0] err_evt_i,
  input logic [AW-1:0] reg_addr_i,
  input logic          reg_we_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic          irq_o,
  input logic [GW-1:0] nrm_stat,
  input logic [GW-1:0] nrm_sten,
  input logic [GW-1:0] nrm_ie,
  input logic [GW-1:0] err_stat,
  input logic [GW-1:0] err_sten,
  input logic [GW-1:0] err_ie
);
  logic [GW-1:0] nrm_take, err_take;
  logic          nrm_wr, err_wr;
  assign nrm_take = nrm_evt_i & nrm_sten & NRM_STAT_MASK;
  assign err_take = err_evt_i & err_sten & ERR_MASK;
  assign nrm_wr   = reg_we_i && reg_addr_i == AW'(OFF_NSTAT);
  assign err_wr   = reg_we_i && reg_addr_i == AW'(OFF_ESTAT);

  // R2 and R8: an enabled event is present after the edge, whatever the write
  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm_take != '0) |=> ((nrm_stat & $past(nrm_take)) == $past(nrm_take)));

  p_event_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_take != '0 && err_wr) |=> ((err_stat & $past(err_take)) == $past(err_take)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nrm_wr && nrm_evt_i == '0) |=> $stable(nrm_stat));

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_wr && (reg_wdata_i[GW-1:0] & ~err_take) != '0)
      |=> ((err_stat & $past(reg_wdata_i[GW-1:0] & ~err_take)) == '0));

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|(nrm_stat & nrm_ie)) | (|(err_stat & err_ie))
                           | ((|err_stat) & nrm_ie[SUM_BIT])));

  p_rsvd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nrm_stat & ~NRM_STAT_MASK) == '0) && ((err_stat & ~ERR_MASK) == '0));
endmodule

bind sd_irq_status sd_irq_status_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .nrm_evt_i, .err_evt_i, .reg_addr_i, .reg_we_i, .reg_wdata_i,
  .irq_o, .nrm_stat, .nrm_sten, .nrm_ie, .err_stat, .err_sten, .err_ie
);

// File: tb/sd_irq_status_test.sv
module sd_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] nrm_evt = '0, err_evt = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  sd_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .nrm_evt_i(nrm_evt), .err_evt_i(err_evt),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] n, input logic [15:0] e);
    nrm_evt = n; err_evt = e;
    tick();
    nrm_evt = '0; err_evt = '0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] v, input string req);
    item_t it;
    addr = a;
    it.is_irq = 1'b0; it.exp = v; it.req = req;
    sb.push_back(it);
    tick();
  endtask

  task automatic exp_irq(input logic v, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, v}; it.req = req;
    sb.push_back(it);
    tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1'b1;
    tick();
    // R1 reset values
    exp_rd(8'h60, 0, "R1"); exp_rd(8'h64, 0, "R1"); exp_rd(8'h68, 0, "R1");
    exp_rd(8'h6C, 0, "R1"); exp_rd(8'h70, 0, "R1"); exp_rd(8'h74, 0, "R1");
    exp_irq(0, "R1");

    // R2 disabled event is not recorded
    pulse(16'h0001, 16'h0010);
    exp_rd(8'h60, 0, "R2"); exp_rd(8'h64, 0, "R2");

    // R9 enable masks keep only defined positions
    wr(8'h68, 32'hFFFF_FFFF); exp_rd(8'h68, 32'h0000_7F3F, "R9");
    wr(8'h6C, 32'hFFFF_FFFF); exp_rd(8'h6C, 32'h0000_7F7F, "R9");

    // R2 command done and auto stop done recorded; R7 no irq with ie=0
    pulse(16'h2001, 16'h0000);
    exp_rd(8'h60, 32'h2001, "R2");
    exp_irq(0, "R7");

    // R7 unrelated enable keeps irq low; enabling bit 13 raises it one edge later
    wr(8'h70, 32'h0002); exp_irq(0, "R7");
    wr(8'h70, 32'h2000); exp_irq(0, "R6");
    exp_irq(1, "R7");

    // R3 status survives status-enable clear
    wr(8'h68, 0); exp_rd(8'h60, 32'h2001, "R3");

    // R4 write-one-to-clear, then read-back-write-back
    wr(8'h60, 32'h0001); exp_rd(8'h60, 32'h2000, "R4");
    wr(8'h60, 32'h2000); exp_rd(8'h60, 0, "R4");
    exp_irq(0, "R6");

    // R5 error summary
    pulse(16'h0000, 16'h0010);
    exp_rd(8'h64, 32'h0010, "R5"); exp_rd(8'h60, 32'h8000, "R5");
    wr(8'h60, 32'h8000); exp_rd(8'h60, 32'h8000, "R5");
    exp_irq(0, "R6");
    wr(8'h70, 32'h8000); tick(); exp_irq(1, "R6");
    wr(8'h64, 32'h0010);
    exp_rd(8'h64, 0, "R5"); exp_rd(8'h60, 0, "R5");
    exp_irq(0, "R6");

    // R8 event wins over coincident clear
    wr(8'h68, 32'h7F3F);
    pulse(16'h0002, 16'h0000);
    addr = 8'h60; wdata = 32'h0006; we = 1'b1; nrm_evt = 16'h0002;
    tick();
    we = 1'b0; wdata = '0; nrm_evt = '0;
    exp_rd(8'h60, 32'h0002, "R8");
    wr(8'h60, 32'h0002); exp_rd(8'h60, 0, "R4");

    // R9 reserved event positions ignored
    pulse(16'h80C0, 16'h8080);
    exp_rd(8'h60, 0, "R9"); exp_rd(8'h64, 0, "R9");
    wr(8'h70, 32'hFFFF_FFFF); exp_rd(8'h70, 32'h0000_FF3F, "R9");

    // R10 unmapped offset reads zero; error ie at 0x74
    exp_rd(8'h78, 0, "R10");
    wr(8'h74, 32'h0001); exp_rd(8'h74, 32'h0001, "R10");
    wr(8'h70, 0);
    pulse(16'h0000, 16'h0001);
    tick(); exp_irq(1, "R6");
    exp_rd(8'h64, 32'h0001, "R10");

    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule